// File: doc/BRIEF.md
# Write Gate Safety Qualifier

This block stands between the raw write-gate request from the data path and the write-gate pin of a disk drive's read/write front end. Seven safety sources can block the request: a host write-disable bit, a sequencer write-disable bit, a missing-timing-mark flag, an address-compare mismatch, and three sticky latches (shock, front-end write error, front-end read error). Each source has a block mask, which stops it from gating the write, and a separate fault mask, which stops it from raising a drive fault. When a source gates a write and its fault is not masked, a write-one-to-clear pending bit is set. The drive-fault signal is the OR of the pending bits.

The front-end error input is compared against the qualified write gate. A mismatch while writing sets the write-error latch, and a mismatch while not writing sets the read-error latch. Both comparisons are suppressed for a programmable blank time after every edge of the qualified write gate. Polarity bits select the active level of the request input, the error input, the shock input and the write-gate output. One bit replaces the comparison with a plain error level. The drive-fault pin is either driven by the block or used as an input that is ORed into a select output.

All settings sit on a simple synchronous register bus with a combinational read port. The block carries no streaming data, so every pin is a plain level and no valid/ready handshake or back-pressure applies.

Top module: `wg_safety_qual`

## Requirements
- R1: The qualified write gate is active only when the request is active and no unmasked source is active. Sources are indexed 0 host_wdis, 1 seq_wdis, 2 mark_missing, 3 address mismatch (addr_match low), 4 shock latch, 5 write-error latch, 6 read-error latch.
- R2: Setting bit i of the block-mask register (address 1) stops source i from gating the write.
- R3: The pending bit i (address 3) sets at the next clock edge in either of two cases. For i = 0..5: source i gates an active request and bit i of the fault-mask register (address 2) is clear. For i = 6: the read-error latch is set and fault-mask bit 6 is clear.
- R4: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. A set in the same cycle wins over a clear.
- R5: The latch register (address 4) holds the shock latch in bit 0. Shock sets it at the active level chosen by configuration bit 13 (1 = active low). It stays set until a 1 is written to it.
- R6: The write-error latch (address 4 bit 1) sets on a mismatch between the error input and the qualified gate while the gate is active. The read-error latch (bit 2) sets on the same mismatch while the gate is inactive. Both latches clear when a 1 is written. A mismatch is ignored from the cycle of a gate edge through the following B cycles, where B is the blank time.
- R7: The configuration register (address 0) resets to 0x00A0. Bits 7:0 hold the blank time B.
- R8: In the configuration register, bit 8 makes the error input active low and bit 10 makes the request input active low. Bit 11 makes qwg_out active low. Bit 9 turns off the comparison: the latches then set whenever the error input is active.
- R9: When configuration bit 12 is set, dflt_oe is high, dflt_out equals the drive fault, and sel_out follows seq_sel_in. When bit 12 is clear, dflt_oe is low and sel_out = seq_sel_in OR dflt_pin_in.
- R10: After reset, masks, pending bits and latches are zero, qwg_out is low and the drive fault is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| wg_req_in | input | 1 | Raw write-gate request |
| ae_err_in | input | 1 | Front-end error input |
| shock_in | input | 1 | Digital shock level |
| mark_missing | input | 1 | Missing timing mark flag |
| addr_match | input | 1 | Address compare valid (high = match) |
| host_wdis | input | 1 | Host write disable |
| seq_wdis | input | 1 | Sequencer write disable |
| seq_sel_in | input | 1 | Sequencer select signal |
| dflt_pin_in | input | 1 | Level read back from the drive-fault pin |
| qwg_out | output | 1 | Qualified write gate |
| sel_out | output | 1 | Select output |
| dflt_out | output | 1 | Drive fault value for the pin |
| dflt_oe | output | 1 | Drive-fault pin output enable |

## Verification
The bench builds the block with its default parameters: 16-bit data, 3-bit address and an 8-bit blank time. It then programs a blank time of 3, so the edges of the ignore window fall within a few cycles. With four directly driven sources, the block-mask and source combinations can be swept exhaustively (256 cases), and both the gate and the pending bits are checked in each case. The small blank time lets the bench count the exact cycle in which a latch first sets after a gate edge.

// File: rtl/wgq_pkg.sv
package wgq_pkg;
  localparam int NSRC = 7;
  localparam int IDX_HOST  = 0;
  localparam int IDX_SEQ   = 1;
  localparam int IDX_MARK  = 2;
  localparam int IDX_ADDR  = 3;
  localparam int IDX_SHOCK = 4;
  localparam int IDX_WERR  = 5;
  localparam int IDX_RERR  = 6;

  localparam int NLAT = 3;
  localparam int LAT_SHOCK = 0;
  localparam int LAT_WERR  = 1;
  localparam int LAT_RERR  = 2;

  localparam int RA_CFG  = 0;
  localparam int RA_BLK  = 1;
  localparam int RA_FLT  = 2;
  localparam int RA_PEND = 3;
  localparam int RA_LAT  = 4;

  // flag field above the blank time, LSB member last
  typedef struct packed {
    logic shock_low;
    logic fpin_en;
    logic qwg_low;
    logic req_low;
    logic cmp_off;
    logic err_low;
  } cfg_t;
endpackage

// File: rtl/wgq_regs.sv
module wgq_regs
  import wgq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3,
  parameter int BLANK_W   = 8,
  parameter int BLANK_RST = 8'hA0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NSRC-1:0]    pend_set,
  input  logic [NLAT-1:0]    lat_set,
  output cfg_t               cfg,
  output logic [BLANK_W-1:0] blank,
  output logic [NSRC-1:0]    blk_mask,
  output logic [NSRC-1:0]    flt_mask,
  output logic [NSRC-1:0]    pend,
  output logic [NLAT-1:0]    lat
);
  localparam int FLAG_W = $bits(cfg_t);
  localparam int CFG_W  = BLANK_W + FLAG_W;

  logic wr_cfg, wr_blk, wr_flt, wr_pend, wr_lat;
  logic [NSRC-1:0] pend_clr;
  logic [NLAT-1:0] lat_clr;
  logic unused_wdata;

  assign wr_cfg  = reg_wr && (reg_addr == ADDR_W'(RA_CFG));
  assign wr_blk  = reg_wr && (reg_addr == ADDR_W'(RA_BLK));
  assign wr_flt  = reg_wr && (reg_addr == ADDR_W'(RA_FLT));
  assign wr_pend = reg_wr && (reg_addr == ADDR_W'(RA_PEND));
  assign wr_lat  = reg_wr && (reg_addr == ADDR_W'(RA_LAT));

  assign pend_clr = wr_pend ? reg_wdata[NSRC-1:0] : '0;
  assign lat_clr  = wr_lat  ? reg_wdata[NLAT-1:0] : '0;
  assign unused_wdata = ^reg_wdata[DATA_W-1:CFG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      blank    <= BLANK_W'(BLANK_RST);
      blk_mask <= '0;
      flt_mask <= '0;
      pend     <= '0;
      lat      <= '0;
    end else begin
      if (wr_cfg) begin
        blank <= reg_wdata[BLANK_W-1:0];
        cfg   <= reg_wdata[BLANK_W +: FLAG_W];
      end
      if (wr_blk) blk_mask <= reg_wdata[NSRC-1:0];
      if (wr_flt) flt_mask <= reg_wdata[NSRC-1:0];
      pend <= (pend & ~pend_clr) | pend_set;
      lat  <= (lat & ~lat_clr) | lat_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (int'(reg_addr))
      RA_CFG:  reg_rdata[CFG_W-1:0] = {cfg, blank};
      RA_BLK:  reg_rdata[NSRC-1:0]  = blk_mask;
      RA_FLT:  reg_rdata[NSRC-1:0]  = flt_mask;
      RA_PEND: reg_rdata[NSRC-1:0]  = pend;
      RA_LAT:  reg_rdata[NLAT-1:0]  = lat;
      default: reg_rdata = '0;
    endcase
  end

  // R4
  pend_w1c_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend) & ~pend)) |-> ($past(reg_wr) && $past(reg_addr) == ADDR_W'(RA_PEND)));

  // R4
  pend_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_set) |=> ((pend & $past(pend_set)) == $past(pend_set)));

  // R5
  lat_w1c_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(lat) & ~lat)) |-> ($past(reg_wr) && $past(reg_addr) == ADDR_W'(RA_LAT)));
endmodule

// File: rtl/wgq_blank.sv
module wgq_blank #(
  parameter int BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               level,
  input  logic [BLANK_W-1:0] blank,
  output logic               chk_en
);
  logic               level_q;
  logic               edge_now;
  logic [BLANK_W-1:0] cnt;

  assign edge_now = level ^ level_q;
  assign chk_en   = !edge_now && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      cnt     <= '0;
    end else begin
      level_q <= level;
      if (edge_now)        cnt <= blank;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  // R6
  blank_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> $stable(level));
endmodule

// File: rtl/wgq_gate.sv
module wgq_gate
  import wgq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_active,
  input  logic [NSRC-1:0] srcs,
  input  logic [NSRC-1:0] blk_mask,
  input  logic [NSRC-1:0] flt_mask,
  output logic            qwg_active,
  output logic [NSRC-1:0] fault_evt
);
  localparam logic [NSRC-1:0] GATED_SRCS = ~(NSRC'(1) << IDX_RERR);

  logic [NSRC-1:0] block_vec;

  assign block_vec  = srcs & ~blk_mask;
  assign qwg_active = req_active && (block_vec == '0);

  for (genvar i = 0; i < NSRC; i++) begin : g_flt
    if (i == IDX_RERR) begin : g_latch
      assign fault_evt[i] = srcs[i] & ~flt_mask[i];
    end else begin : g_block
      assign fault_evt[i] = req_active & block_vec[i] & ~flt_mask[i];
    end
  end

  // R3
  fault_means_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fault_evt & GATED_SRCS)) |-> !qwg_active);
endmodule

// File: rtl/wg_safety_qual.sv
module wg_safety_qual
  import wgq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3,
  parameter int BLANK_W   = 8,
  parameter int BLANK_RST = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              wg_req_in,
  input  logic              ae_err_in,
  input  logic              shock_in,
  input  logic              mark_missing,
  input  logic              addr_match,
  input  logic              host_wdis,
  input  logic              seq_wdis,
  input  logic              seq_sel_in,
  input  logic              dflt_pin_in,
  output logic              qwg_out,
  output logic              sel_out,
  output logic              dflt_out,
  output logic              dflt_oe
);
  cfg_t               cfg;
  logic [BLANK_W-1:0] blank;
  logic [NSRC-1:0]    blk_mask, flt_mask, pend, srcs, fault_evt;
  logic [NLAT-1:0]    lat, lat_set;
  logic               req_active, qwg_active, err_active, mismatch, chk_en;
  logic               drive_fault;

  wgq_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLANK_W(BLANK_W), .BLANK_RST(BLANK_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pend_set(fault_evt),
    .lat_set(lat_set), .cfg(cfg), .blank(blank), .blk_mask(blk_mask),
    .flt_mask(flt_mask), .pend(pend), .lat(lat)
  );

  assign req_active = wg_req_in ^ cfg.req_low;

  always_comb begin
    srcs            = '0;
    srcs[IDX_HOST]  = host_wdis;
    srcs[IDX_SEQ]   = seq_wdis;
    srcs[IDX_MARK]  = mark_missing;
    srcs[IDX_ADDR]  = ~addr_match;
    srcs[IDX_SHOCK] = lat[LAT_SHOCK];
    srcs[IDX_WERR]  = lat[LAT_WERR];
    srcs[IDX_RERR]  = lat[LAT_RERR];
  end

  wgq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .req_active(req_active), .srcs(srcs),
    .blk_mask(blk_mask), .flt_mask(flt_mask), .qwg_active(qwg_active),
    .fault_evt(fault_evt)
  );

  wgq_blank #(.BLANK_W(BLANK_W)) u_blank (
    .clk(clk), .rst_n(rst_n), .level(qwg_active), .blank(blank), .chk_en(chk_en)
  );

  assign err_active = ae_err_in ^ cfg.err_low;
  assign mismatch   = cfg.cmp_off ? err_active : (err_active ^ qwg_active);

  always_comb begin
    lat_set            = '0;
    lat_set[LAT_SHOCK] = shock_in ^ cfg.shock_low;
    lat_set[LAT_WERR]  = chk_en & qwg_active & mismatch;
    lat_set[LAT_RERR]  = chk_en & ~qwg_active & mismatch;
  end

  assign drive_fault = |pend;
  assign qwg_out     = qwg_active ^ cfg.qwg_low;
  assign dflt_out    = drive_fault;
  assign dflt_oe     = cfg.fpin_en;
  assign sel_out     = seq_sel_in | (~cfg.fpin_en & dflt_pin_in);

  // R1
  host_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wdis && !blk_mask[IDX_HOST]) |-> !qwg_active);

  // R9
  fault_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.fpin_en && (|pend)) |-> (dflt_out && dflt_oe));
endmodule

// File: tb/sim_wg_safety_qual.sv
`timescale 1ns/1ps
module sim_wg_safety_qual;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic wg_req_in = 0, ae_err_in = 0, shock_in = 0, mark_missing = 0;
  logic addr_match = 1, host_wdis = 0, seq_wdis = 0, seq_sel_in = 0, dflt_pin_in = 0;
  logic qwg_out, sel_out, dflt_out, dflt_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wg_safety_qual u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wg_req_in(wg_req_in),
    .ae_err_in(ae_err_in), .shock_in(shock_in), .mark_missing(mark_missing),
    .addr_match(addr_match), .host_wdis(host_wdis), .seq_wdis(seq_wdis),
    .seq_sel_in(seq_sel_in), .dflt_pin_in(dflt_pin_in), .qwg_out(qwg_out),
    .sel_out(sel_out), .dflt_out(dflt_out), .dflt_oe(dflt_oe)
  );

  // configuration bit positions
  localparam logic [15:0] C_ERRLO = 16'h0100, C_CMPOFF = 16'h0200,
    C_REQLO = 16'h0400, C_QWGLO = 16'h0800, C_FPIN = 16'h1000, C_SHKLO = 16'h2000;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    reg_addr = 3'(a); #1; v = reg_rdata;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] cfg_v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R10 / R7 reset state
    rd(0, v); chk("R7 cfg reset", v, 16'h00A0);
    rd(1, v); chk("R10 blk mask reset", v, 0);
    rd(2, v); chk("R10 flt mask reset", v, 0);
    rd(3, v); chk("R10 pend reset", v, 0);
    rd(4, v); chk("R10 latch reset", v, 0);
    chk("R10 qwg reset", qwg_out, 0);
    chk("R10 fault reset", dflt_out, 0);

    // exhaustive sweep of 4 direct sources x 4 block-mask bits
    cfg_v = C_CMPOFF | C_FPIN | 16'h0003;
    wr(0, cfg_v);
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 16; s++) begin
        logic [3:0] blk;
        wg_req_in = 0; host_wdis = 0; seq_wdis = 0; mark_missing = 0; addr_match = 1;
        wr(1, 16'(m));
        wr(3, 16'h007F);
        host_wdis = s[0]; seq_wdis = s[1]; mark_missing = s[2]; addr_match = ~s[3];
        wg_req_in = 1;
        blk = 4'(s) & ~4'(m);
        tick();
        chk("R1/R2 gate sweep", qwg_out, (blk == 0));
        rd(3, v);
        chk("R3 pend sweep", v, 16'(blk));
        chk("R9 fault out sweep", dflt_out, (blk != 0));
      end
    end
    wg_req_in = 0; host_wdis = 0; seq_wdis = 0; mark_missing = 0; addr_match = 1;
    wr(1, 0);
    wr(3, 16'h007F);

    // R3 fault mask
    wr(2, 16'h0005);
    host_wdis = 1; seq_wdis = 1; mark_missing = 1; addr_match = 0; wg_req_in = 1;
    tick();
    chk("R1 blocked all", qwg_out, 0);
    rd(3, v); chk("R3 fault mask", v, 16'h000A);
    wg_req_in = 0; host_wdis = 0; seq_wdis = 0; mark_missing = 0; addr_match = 1;
    wr(2, 0);
    // R4 write-one-to-clear
    wr(3, 16'h0002); rd(3, v); chk("R4 w1c one bit", v, 16'h0008);
    wr(3, 16'h0000); rd(3, v); chk("R4 write zero no effect", v, 16'h0008);
    wr(3, 16'h0008); rd(3, v); chk("R4 cleared", v, 0);
    chk("R3 drive fault off", dflt_out, 0);

    // R5 shock latch
    shock_in = 1; tick(); shock_in = 0; tick();
    rd(4, v); chk("R5 shock sticky", v, 16'h0001);
    wg_req_in = 1; #1;
    chk("R1 shock blocks", qwg_out, 0);
    tick();
    rd(3, v); chk("R3 shock pend", v, 16'h0010);
    wg_req_in = 0;
    wr(4, 16'h0001); wr(3, 16'h007F);
    rd(4, v); chk("R5 shock cleared", v, 0);
    cfg_v = cfg_v | C_SHKLO; shock_in = 1;
    wr(0, cfg_v);
    wr(4, 16'h0001);
    tick(); tick();
    rd(4, v); chk("R5 active-low idle", v, 0);
    shock_in = 0; tick();
    rd(4, v); chk("R5 active-low set", v, 16'h0001);
    cfg_v = C_FPIN | 16'h0003;
    wr(0, cfg_v);
    repeat (6) tick();
    wr(4, 16'h0007); wr(3, 16'h007F);
    rd(4, v); chk("R6 latches clear", v, 0);

    // R6 write-error latch with blank window of 3
    wg_req_in = 1; ae_err_in = 0;
    repeat (4) tick();
    rd(4, v); chk("R6 blanked", v, 0);
    tick();
    rd(4, v); chk("R6 write err after blank", v, 16'h0002);
    chk("R1 write err blocks", qwg_out, 0);
    wg_req_in = 0;
    repeat (6) tick();
    wr(4, 16'h0007); wr(3, 16'h007F);

    // R6 read-error latch and its fault
    ae_err_in = 1; tick();
    rd(4, v); chk("R6 read err", v, 16'h0004);
    tick();
    rd(3, v); chk("R3 read err pend", v, 16'h0040);
    ae_err_in = 0;
    wr(4, 16'h0007); wr(3, 16'h007F);

    // R8 error active low
    cfg_v = cfg_v | C_ERRLO; ae_err_in = 1;
    wr(0, cfg_v);
    wr(4, 16'h0007);
    repeat (3) tick();
    rd(4, v); chk("R8 err low idle", v, 0);
    ae_err_in = 0; tick();
    rd(4, v); chk("R8 err low set", v, 16'h0004);
    ae_err_in = 1;
    cfg_v = C_FPIN | 16'h0003;
    ae_err_in = 0;
    wr(0, cfg_v);
    wr(4, 16'h0007); wr(3, 16'h007F);

    // R6 match while writing, then R8 comparison off
    wg_req_in = 1; ae_err_in = 1;
    repeat (6) tick();
    rd(4, v); chk("R6 match no latch", v, 0);
    chk("R1 write active", qwg_out, 1);
    cfg_v = cfg_v | C_CMPOFF;
    wr(0, cfg_v);
    tick();
    rd(4, v); chk("R8 cmp off sets", v, 16'h0002);
    wg_req_in = 0; ae_err_in = 0;
    repeat (6) tick();
    wr(4, 16'h0007); wr(3, 16'h007F);

    // R8 request and output polarity
    cfg_v = C_CMPOFF | C_REQLO | C_QWGLO | 16'h0003;
    wg_req_in = 1;
    wr(0, cfg_v);
    chk("R8 req low inactive", qwg_out, 1);
    wg_req_in = 0; #1;
    chk("R8 req low active", qwg_out, 0);
    cfg_v = C_CMPOFF | 16'h0003;
    wr(0, cfg_v);
    chk("R8 normal polarity idle", qwg_out, 0);

    // R9 fault pin
    for (int k = 0; k < 4; k++) begin
      seq_sel_in = k[0]; dflt_pin_in = k[1]; #1;
      chk("R9 pin as input", sel_out, k[0] | k[1]);
      chk("R9 oe off", dflt_oe, 0);
    end
    wr(0, cfg_v | C_FPIN);
    seq_sel_in = 0; dflt_pin_in = 1; #1;
    chk("R9 pin driven sel", sel_out, 0);
    chk("R9 oe on", dflt_oe, 1);
    host_wdis = 1; wg_req_in = 1; tick();
    chk("R9 drives fault", dflt_out, 1);

    done = 1;
    finish_run();
  end
endmodule